// File: doc/BRIEF.md
# Calibration Memory Write Lock

This block guards the calibration part of a static RAM against stray writes. A free-running cycle counter restarts whenever the shared timer-restart strobe pulses. Once the count reaches an arming point, a short acceptance window opens. The processor opens the calibration area by placing a special unlock access on the bus inside that window. The access is an address pattern that is qualified by the low phase of the bus timing strobe. When this happens, the active-low unlock output drops and writes to the protected area are allowed through.

An unlock access that comes before the arming point trips a lockout. The lockout holds the memory locked until the next timer restart, even if a correct request follows later in the same period. An access after the window has closed does nothing. Ordinary RAM writes outside the protected area are never blocked. The block also drives the registered chip-select decodes for the unlock access and for the RAM, and a lock-status flag.

Top module: `cwl_cal_guard`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `unlock_n`, `locked` and `mem_we_n` are 1, and `cal_sel` and `ram_sel` are 0.
- R2: `cal_sel` is 1 in the cycle after a cycle in which all of the following hold: address bit 11 = 1, bit 12 = 1, bit 13 = 0 and `e_strobe` = 0. Otherwise it is 0, and such a cycle is the only thing that can count as an unlock request.
- R3: `ram_sel` is 1 in the cycle after a cycle with address bit 11 = 0, bit 12 = 1 and bit 13 = 0, whatever the level of `e_strobe`.
- R4: An unlock request is the first cycle of an R2 hit. Let N be the number of clock edges since the last restart. If N satisfies ARM_CYC ≤ N < ARM_CYC+WIN_CYC and no lockout is pending, `unlock_n` goes to 0 on the following cycle.
- R5: A request with N < ARM_CYC leaves `unlock_n` at 1 and sets a lockout. While the lockout is set, a later request inside the window in the same period does not unlock.
- R6: A request with N ≥ ARM_CYC+WIN_CYC does not change `unlock_n`. The count stops at ARM_CYC+WIN_CYC, so the window stays closed.
- R7: A `tmr_restart` pulse, or `rst`, sets the count back to zero, clears the lockout and drives `unlock_n` back to 1 on the next cycle. A fresh unlock attempt then succeeds.
- R8: A cycle with `wr_req` = 1, a RAM address (R3) and address bits 9 and 10 both 1 gives `mem_we_n` = 0 on the next cycle only if the memory is unlocked. Otherwise `mem_we_n` stays 1.
- R9: A cycle with `wr_req` = 1 and a RAM address without both bits 9 and 10 set gives `mem_we_n` = 0 on the next cycle, locked or not.
- R10: `locked` is 1 exactly when `unlock_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_restart | input | 1 | Timer restart strobe (one cycle) |
| bus_addr | input | 5 | Address bits 13 down to 9 |
| e_strobe | input | 1 | Bus timing strobe, unlock access qualified while low |
| wr_req | input | 1 | Processor write request |
| unlock_n | output | 1 | Active-low unlock state of the calibration area |
| locked | output | 1 | Lock status flag |
| mem_we_n | output | 1 | Active-low RAM write enable, gated for the protected area |
| cal_sel | output | 1 | Registered unlock-access decode |
| ram_sel | output | 1 | Registered RAM chip-select decode |

## Verification
The bench builds the block with ARM_CYC = 16 and WIN_CYC = 4 instead of thousands of cycles. This makes every window edge easy to reach: the last early count, the first and last valid counts, the first late count, and a point well past the count's saturation. Each of these runs in a few dozen cycles. With such short periods, a single run can also cover lockout followed by a valid request, relocking on restart, and protected against unprotected writes in both lock states.

// File: rtl/cwl_pkg.sv
package cwl_pkg;

  // Upper address lines that the block decodes
  localparam int unsigned ADDR_HI = 13;
  localparam int unsigned ADDR_LO = 9;
  localparam int unsigned ADDR_W  = ADDR_HI - ADDR_LO + 1;

  // Bit positions inside the upper-address slice
  localparam int unsigned B_PROT_A = 9  - ADDR_LO;
  localparam int unsigned B_PROT_B = 10 - ADDR_LO;
  localparam int unsigned B_SEL_L  = 11 - ADDR_LO;
  localparam int unsigned B_SEL_M  = 12 - ADDR_LO;
  localparam int unsigned B_SEL_H  = 13 - ADDR_LO;

  typedef struct packed {
    logic cal;   // unlock-access region
    logic ram;   // ordinary RAM region
    logic prot;  // protected calibration area within RAM
  } dec_t;

  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
    dec_t d;
    d.cal  = a[B_SEL_L] & a[B_SEL_M] & ~a[B_SEL_H];
    d.ram  = ~a[B_SEL_L] & a[B_SEL_M] & ~a[B_SEL_H];
    d.prot = a[B_PROT_A] & a[B_PROT_B];
    return d;
  endfunction

endpackage

// File: rtl/cwl_timer.sv
module cwl_timer #(
  parameter int unsigned ARM_CYC = 8192,
  parameter int unsigned WIN_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic armed,
  output logic in_win,
  output logic late
);
  localparam int unsigned LIMIT = ARM_CYC + WIN_CYC;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (cnt != CW'(LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    armed  = (cnt >= CW'(ARM_CYC));
    late   = (cnt >= CW'(LIMIT));
    in_win = armed & ~late;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT)) else $error("count passed limit"); // R6

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> !armed) else $error("armed right after restart"); // R7

endmodule

// File: rtl/cwl_decode.sv
module cwl_decode
  import cwl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              e_strobe,
  output logic              cal_req,
  output logic              ram_hit,
  output logic              prot_hit,
  output logic              cal_sel,
  output logic              ram_sel
);
  dec_t d;
  logic cal_hit;
  logic cal_q;

  always_comb begin
    d        = decode_addr(addr);
    cal_hit  = d.cal & ~e_strobe;
    ram_hit  = d.ram;
    prot_hit = d.prot;
    cal_req  = cal_hit & ~cal_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q   <= 1'b0;
      cal_sel <= 1'b0;
      ram_sel <= 1'b0;
    end else begin
      cal_q   <= cal_hit;
      cal_sel <= cal_hit;
      ram_sel <= d.ram;
    end
  end

  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cal_sel && ram_sel)) else $error("both selects active"); // R3

  AST_REQ_FIRST: assert property (@(posedge clk) disable iff (rst)
    cal_req |=> !cal_req) else $error("request repeated"); // R4

  AST_E_QUAL: assert property (@(posedge clk) disable iff (rst)
    e_strobe |=> !cal_sel) else $error("cal select with strobe high"); // R2

endmodule

// File: rtl/cwl_lockfsm.sv
module cwl_lockfsm (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic req,
  input  logic armed,
  input  logic in_win,
  input  logic late,
  output logic unlocked,
  output logic lockout
);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      unlocked <= 1'b0;
      lockout  <= 1'b0;
    end else if (req) begin
      if (!armed) begin
        lockout  <= 1'b1;
        unlocked <= 1'b0;
      end else if (in_win && !lockout) begin
        unlocked <= 1'b1;
      end
    end
  end

  AST_EARLY_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (req && !armed && !restart) |=> (lockout && !unlocked))
    else $error("early request did not lock"); // R5

  AST_WIN_OPENS: assert property (@(posedge clk) disable iff (rst)
    (req && in_win && !lockout && !restart) |=> unlocked)
    else $error("window request did not unlock"); // R4

  AST_LATE_INERT: assert property (@(posedge clk) disable iff (rst)
    (req && late && !restart) |=> $stable(unlocked))
    else $error("late request changed state"); // R6

  AST_RESTART_RELOCK: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!unlocked && !lockout))
    else $error("restart did not relock"); // R7

endmodule

// File: rtl/cwl_cal_guard.sv
module cwl_cal_guard
  import cwl_pkg::*;
#(
  parameter int unsigned ARM_CYC = 8192,
  parameter int unsigned WIN_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmr_restart,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              e_strobe,
  input  logic              wr_req,
  output logic              unlock_n,
  output logic              locked,
  output logic              mem_we_n,
  output logic              cal_sel,
  output logic              ram_sel
);
  logic armed, in_win, late;
  logic cal_req, ram_hit, prot_hit;
  logic unlocked, lockout;

  cwl_timer #(.ARM_CYC(ARM_CYC), .WIN_CYC(WIN_CYC)) u_timer (
    .clk(clk), .rst(rst), .restart(tmr_restart),
    .armed(armed), .in_win(in_win), .late(late)
  );

  cwl_decode u_dec (
    .clk(clk), .rst(rst), .addr(bus_addr), .e_strobe(e_strobe),
    .cal_req(cal_req), .ram_hit(ram_hit), .prot_hit(prot_hit),
    .cal_sel(cal_sel), .ram_sel(ram_sel)
  );

  cwl_lockfsm u_fsm (
    .clk(clk), .rst(rst), .restart(tmr_restart), .req(cal_req),
    .armed(armed), .in_win(in_win), .late(late),
    .unlocked(unlocked), .lockout(lockout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we_n <= 1'b1;
    end else begin
      mem_we_n <= ~(wr_req & ram_hit & (~prot_hit | unlocked));
    end
  end

  assign unlock_n = ~unlocked;
  assign locked   = ~unlocked;

  AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (wr_req && ram_hit && prot_hit && !unlocked) |=> mem_we_n)
    else $error("protected write passed while locked"); // R8

  AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_req && ram_hit && !prot_hit) |=> !mem_we_n)
    else $error("ordinary write blocked"); // R9

  AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lockout && !tmr_restart) |=> unlock_n)
    else $error("unlocked during lockout"); // R5

endmodule

// File: tb/sim_cwl_cal_guard.sv
`timescale 1ns/1ps
module sim_cwl_cal_guard;
  localparam int unsigned ARM = 16;
  localparam int unsigned WIN = 4;

  // upper address slice [13:9]
  localparam logic [4:0] A_CAL  = 5'b01100; // bit11,bit12
  localparam logic [4:0] A_CALX = 5'b11100; // bit13 also set
  localparam logic [4:0] A_RAM  = 5'b01000; // bit12
  localparam logic [4:0] A_PROT = 5'b01011; // bit12,bit10,bit9
  localparam logic [4:0] A_IDLE = 5'b00000;

  // rows: request count N, strobe low?, expected unlock_n
  localparam int VEC [7][3] = '{
    '{0, 1, 1}, '{15, 1, 1}, '{16, 1, 0}, '{19, 1, 0},
    '{20, 1, 1}, '{40, 1, 1}, '{17, 0, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tmr_restart = 1'b0;
  logic [4:0] bus_addr = A_IDLE;
  logic e_strobe = 1'b1;
  logic wr_req = 1'b0;
  logic unlock_n, locked, mem_we_n, cal_sel, ram_sel;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cwl_cal_guard #(.ARM_CYC(ARM), .WIN_CYC(WIN)) u0 (
    .clk(clk), .rst(rst), .tmr_restart(tmr_restart), .bus_addr(bus_addr),
    .e_strobe(e_strobe), .wr_req(wr_req), .unlock_n(unlock_n),
    .locked(locked), .mem_we_n(mem_we_n), .cal_sel(cal_sel), .ram_sel(ram_sel)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_bus();
    bus_addr = A_IDLE; e_strobe = 1'b1; wr_req = 1'b0;
  endtask

  task automatic restart_timer();
    @(negedge clk) tmr_restart = 1'b1;
    @(negedge clk) tmr_restart = 1'b0;
  endtask

  // Waits n cycles, then issues one request seen at count n (relative)
  task automatic cal_at(input int n, input logic e_low, input logic [4:0] a);
    repeat (n) @(negedge clk);
    bus_addr = a; e_strobe = ~e_low;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic write_at(input logic [4:0] a);
    @(negedge clk);
    bus_addr = a; wr_req = 1'b1;
    @(negedge clk);
    idle_bus();
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle_bus();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 unlock_n", unlock_n, 1'b1);
    check("R1 locked", locked, 1'b1);
    check("R1 mem_we_n", mem_we_n, 1'b1);
    check("R1 cal_sel", cal_sel, 1'b0);
    check("R1 ram_sel", ram_sel, 1'b0);
    rst = 1'b0;

    // table walk over window edges
    for (int i = 0; i < 7; i++) begin
      string tag;
      if (VEC[i][1] == 0) tag = "R2 strobe-high";
      else if (VEC[i][0] < ARM) tag = "R5 early";
      else if (VEC[i][0] < ARM + WIN) tag = "R4 window";
      else tag = "R6 late";
      restart_timer();
      cal_at(VEC[i][0], VEC[i][1] != 0, A_CAL);
      check(tag, unlock_n, VEC[i][2] != 0);
      check("R2 cal_sel", cal_sel, VEC[i][1] != 0);
      check("R10 locked", locked, unlock_n);
    end

    // R5 lockout blocks a later window request
    restart_timer();
    cal_at(5, 1'b1, A_CAL);      // count 5
    cal_at(10, 1'b1, A_CAL);     // count 16
    check("R5 lockout persists", unlock_n, 1'b1);

    // R7 restart clears lockout, then unlock succeeds, then relocks
    restart_timer();
    check("R7 relocked", unlock_n, 1'b1);
    cal_at(16, 1'b1, A_CAL);
    check("R7 fresh unlock", unlock_n, 1'b0);
    // R8 protected write while unlocked
    write_at(A_PROT);
    check("R8 prot unlocked", mem_we_n, 1'b0);
    check("R3 ram_sel", ram_sel, 1'b1);
    restart_timer();
    check("R7 restart relocks", unlock_n, 1'b1);
    check("R10 status", locked, 1'b1);

    // R2 wrong region: bit13 set is no request
    restart_timer();
    cal_at(16, 1'b1, A_CALX);
    check("R2 bit13 cal_sel", cal_sel, 1'b0);
    check("R2 bit13 no unlock", unlock_n, 1'b1);

    // R8 / R9 writes while locked
    write_at(A_PROT);
    check("R8 prot locked", mem_we_n, 1'b1);
    write_at(A_RAM);
    check("R9 open write", mem_we_n, 1'b0);
    check("R3 ram_sel", ram_sel, 1'b1);
    @(negedge clk);
    check("R9 write ends", mem_we_n, 1'b1);
    check("R3 ram_sel idle", ram_sel, 1'b0);

    // R3 strobe-independent RAM decode
    @(negedge clk) begin bus_addr = A_RAM; e_strobe = 1'b0; end
    @(negedge clk);
    check("R3 ram_sel strobe low", ram_sel, 1'b1);
    check("R2 cal_sel on ram", cal_sel, 1'b0);
    idle_bus();

    // R1 reset in the middle of an unlocked state
    restart_timer();
    cal_at(17, 1'b1, A_CAL);
    check("R4 unlock", unlock_n, 1'b0);
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R1 reset relocks", unlock_n, 1'b1);
    rst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule